// File: doc/BRIEF.md
# Bridge Drive Fault and Standby Supervisor

This block sits between the raw protection flags of a two-winding stepper bridge and the gate logic. It decides, on every clock, whether the charge pump may run and whether the bridge outputs may drive. It takes the standby pin, two supply-good flags, an over-temperature flag, a temperature-recovered flag and a raw overcurrent flag, all asynchronous. It also takes a single-cycle tick from the chopper oscillator, which is already synchronous to the clock.

Overcurrent must last for a dead time counted in oscillator ticks before it trips. This keeps switching spikes from shutting the bridge down. Thermal and overcurrent trips both latch, and only a standby low-then-high sequence releases them. A thermal trip is released only if the temperature has already recovered at that moment. Once the pump starts, the outputs stay off for a configurable start-up wait, so the pump voltage has time to build.

Top module: `bridge_supervisor`

## Requirements
- R1: While either synchronised supply-good flag is low, `pumpRun` and `outEnable` are 0 and `faultCode` is 1. This also holds straight out of reset, until both flags have passed the synchroniser. A supply dip is not latched: when it ends, the pump restarts and the start-up wait is counted again.
- R2: While synchronised standby is low, `pumpRun` and `outEnable` are 0.
- R3: Overcurrent trips only after the synchronised flag has stayed high across `DEAD_TICKS` oscillator ticks. The trip takes effect on the clock after the last of those ticks. After a trip, `faultCode` is 3 (when no higher fault is present), and `pumpRun` and `outEnable` are 0.
- R4: If the synchronised overcurrent flag falls before the dead time completes, the tick count restarts from zero and no trip occurs.
- R5: The overcurrent trip stays latched after the flag clears. It is released on the first clock on which synchronised standby is seen high after being low.
- R6: A synchronised over-temperature flag sets a thermal latch at once. The latch drives `thermalProtect` to 1 and forces `pumpRun` and `outEnable` to 0.
- R7: A standby low-to-high sequence releases the thermal latch only if the synchronised temperature-recovered flag is high on that rising edge. Otherwise the latch stays set.
- R8: `pumpReady` rises after `pumpRun` has been high for `WAIT_CYCLES` consecutive clocks. `outEnable` equals `pumpRun` AND `pumpReady`. The wait restarts whenever `pumpRun` drops.
- R9: `faultCode` encodes 0 = none, 1 = supply low, 2 = thermal latched, 3 = overcurrent latched. When more than one fault is present, it reports the highest in the order supply, then thermal, then overcurrent.
- R10: Every asynchronous flag passes through two flip-flops. An input change drives no output earlier than the second rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standbyIn | input | 1 | Standby pin, high = operate (async) |
| logicSupplyOk | input | 1 | Logic supply above return level (async) |
| motorSupplyOk | input | 1 | Motor supply above return level (async) |
| overTemp | input | 1 | Junction over-temperature flag (async) |
| tempRecovered | input | 1 | Temperature below hysteresis return level (async) |
| overCurrentRaw | input | 1 | Unfiltered bridge overcurrent flag (async) |
| oscTick | input | 1 | One-clock pulse per chopper oscillator period |
| outEnable | output | 1 | Global bridge output enable |
| pumpRun | output | 1 | Charge pump run request |
| pumpReady | output | 1 | Start-up wait completed |
| faultCode | output | 2 | Prioritised fault code |
| thermalProtect | output | 1 | Thermal latch status |

## Verification
The bench drives an overcurrent pulse that spans fewer than `DEAD_TICKS` ticks. A design that kept its partial count would then trip on a later short pulse, or would trip on the first one. It toggles standby while the temperature-recovered flag is low: a design that cleared on standby alone would bring back the outputs and the pump too early. It stacks a supply dip, a thermal latch and an overcurrent latch together to expose a wrong priority order, and it times a standby change to the clock to catch a missing or extra synchroniser stage. A cycle-accurate reference model is compared on every clock, so any fault in the start-up wait restart shows up as an early or late `outEnable`.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
  localparam int FLAG_STBY  = 0;
  localparam int FLAG_LOGIC = 1;
  localparam int FLAG_MOTOR = 2;
  localparam int FLAG_OT    = 3;
  localparam int FLAG_TREC  = 4;
  localparam int FLAG_OC    = 5;
  localparam int NUM_FLAGS  = 6;

  typedef struct packed {
    logic clearDead;   // standby rise seen: restart dead-time count
    logic pumpOn;      // pump running: advance start-up wait
  } supStrobe_t;

  typedef enum logic [1:0] {
    FAULT_NONE        = 2'd0,
    FAULT_SUPPLY      = 2'd1,
    FAULT_THERMAL     = 2'd2,
    FAULT_OVERCURRENT = 2'd3
  } faultCode_e;
endpackage

// File: rtl/sup_datapath.sv
`timescale 1ns/1ps
module sup_datapath
  import sup_pkg::*;
#(
  parameter int DEAD_TICKS  = 4,
  parameter int WAIT_CYCLES = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] rawFlags,
  input  logic                 oscTick,
  input  supStrobe_t           strobe,
  output logic [FLAG_OC-1:0]   syncCtl,
  output logic                 deadExpired,
  output logic                 waitDone
);
  localparam int DEAD_W = $clog2(DEAD_TICKS);
  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [DEAD_W-1:0] DEAD_LAST = DEAD_W'(DEAD_TICKS - 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYCLES);

  logic [NUM_FLAGS-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_FLAGS-1:0] syncOut;
  logic [DEAD_W-1:0]    deadCnt;
  logic [WAIT_W-1:0]    waitCnt;
  logic                 ocSync;

  // Synchroniser chain for every asynchronous flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= '0;
    end else begin
      syncPipe[0] <= rawFlags;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign syncOut = syncPipe[SYNC_STAGES-1];
  assign syncCtl = syncOut[FLAG_OC-1:0];
  assign ocSync  = syncOut[FLAG_OC];

  // Overcurrent dead time, counted in oscillator ticks
  assign deadExpired = ocSync && oscTick && (deadCnt == DEAD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         deadCnt <= '0;
    else if (!ocSync || strobe.clearDead) deadCnt <= '0;
    else if (oscTick)                  deadCnt <= (deadCnt == DEAD_LAST) ? '0 : deadCnt + 1'b1;
  end

  // Charge-pump start-up wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   waitCnt <= '0;
    else if (!strobe.pumpOn)     waitCnt <= '0;
    else if (waitCnt != WAIT_LAST) waitCnt <= waitCnt + 1'b1;
  end

  assign waitDone = (waitCnt == WAIT_LAST);

  // R3: a trip needs the flag held since at least the previous clock
  assert_dead_needs_history_R3: assert property (@(posedge clk) disable iff (!rstN)
    deadExpired |-> $past(ocSync));

  // R8: start-up counter never passes its limit
  assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WAIT_LAST);
endmodule

// File: rtl/sup_control.sv
`timescale 1ns/1ps
module sup_control
  import sup_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [FLAG_OC-1:0] syncCtl,
  input  logic               deadExpired,
  input  logic               waitDone,
  output supStrobe_t         strobe,
  output logic               outEnable,
  output logic               pumpRun,
  output logic               pumpReady,
  output logic               thermalProtect,
  output logic [1:0]         faultCode
);
  logic stbyPrev, stbyRise, supplyLow, ocLatch, thLatch;
  faultCode_e code;

  assign stbyRise  = syncCtl[FLAG_STBY] & ~stbyPrev;
  assign supplyLow = ~(syncCtl[FLAG_LOGIC] & syncCtl[FLAG_MOTOR]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbyPrev <= 1'b0;
      ocLatch  <= 1'b0;
      thLatch  <= 1'b0;
    end else begin
      stbyPrev <= syncCtl[FLAG_STBY];
      if (stbyRise)         ocLatch <= 1'b0;
      else if (deadExpired) ocLatch <= 1'b1;
      if (syncCtl[FLAG_OT])                       thLatch <= 1'b1;
      else if (stbyRise && syncCtl[FLAG_TREC])    thLatch <= 1'b0;
    end
  end

  assign pumpRun        = syncCtl[FLAG_STBY] & ~supplyLow & ~thLatch & ~ocLatch;
  assign pumpReady      = waitDone;
  assign outEnable      = pumpRun & waitDone;
  assign thermalProtect = thLatch;

  always_comb begin
    strobe.clearDead = stbyRise;
    strobe.pumpOn    = pumpRun;
  end

  always_comb begin
    if (supplyLow)    code = FAULT_SUPPLY;
    else if (thLatch) code = FAULT_THERMAL;
    else if (ocLatch) code = FAULT_OVERCURRENT;
    else              code = FAULT_NONE;
  end
  assign faultCode = code;

  // R7: thermal release only with recovered temperature
  assert_thermal_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(thLatch) |-> $past(syncCtl[FLAG_TREC]));

  // R5: overcurrent release only on a standby rise
  assert_oc_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ocLatch) |-> $past(stbyRise));
endmodule

// File: rtl/bridge_supervisor.sv
`timescale 1ns/1ps
module bridge_supervisor
  import sup_pkg::*;
#(
  parameter int DEAD_TICKS  = 4,
  parameter int WAIT_CYCLES = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       standbyIn,
  input  logic       logicSupplyOk,
  input  logic       motorSupplyOk,
  input  logic       overTemp,
  input  logic       tempRecovered,
  input  logic       overCurrentRaw,
  input  logic       oscTick,
  output logic       outEnable,
  output logic       pumpRun,
  output logic       pumpReady,
  output logic [1:0] faultCode,
  output logic       thermalProtect
);
  logic [NUM_FLAGS-1:0] rawFlags;
  logic [FLAG_OC-1:0]   syncCtl;
  logic                 deadExpired, waitDone;
  supStrobe_t           strobe;

  always_comb begin
    rawFlags             = '0;
    rawFlags[FLAG_STBY]  = standbyIn;
    rawFlags[FLAG_LOGIC] = logicSupplyOk;
    rawFlags[FLAG_MOTOR] = motorSupplyOk;
    rawFlags[FLAG_OT]    = overTemp;
    rawFlags[FLAG_TREC]  = tempRecovered;
    rawFlags[FLAG_OC]    = overCurrentRaw;
  end

  sup_datapath #(
    .DEAD_TICKS(DEAD_TICKS), .WAIT_CYCLES(WAIT_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .rawFlags(rawFlags), .oscTick(oscTick),
    .strobe(strobe), .syncCtl(syncCtl), .deadExpired(deadExpired), .waitDone(waitDone)
  );

  sup_control i_control (
    .clk(clk), .rstN(rstN), .syncCtl(syncCtl), .deadExpired(deadExpired),
    .waitDone(waitDone), .strobe(strobe), .outEnable(outEnable), .pumpRun(pumpRun),
    .pumpReady(pumpReady), .thermalProtect(thermalProtect), .faultCode(faultCode)
  );

  // R9: driving implies no fault reported
  assert_drive_no_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    outEnable |-> (faultCode == 2'd0));

  // R6: thermal latch and pump never on together
  assert_thermal_stops_pump_R6: assert property (@(posedge clk) disable iff (!rstN)
    thermalProtect |-> !pumpRun);

  // R8: drive starts only after the pump was already running
  assert_drive_after_pump_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEnable) |-> $past(pumpRun));
endmodule

// File: tb/test_bridge_supervisor.sv
`timescale 1ns/1ps
module test_bridge_supervisor;
  localparam int DEAD = 4;
  localparam int WAITC = 12;
  localparam int TICK_GAP = 5;

  logic clk = 0, rstN = 0;
  logic standbyIn = 0, logicSupplyOk = 1, motorSupplyOk = 1;
  logic overTemp = 0, tempRecovered = 0, overCurrentRaw = 0, oscTick = 0;
  logic outEnable, pumpRun, pumpReady, thermalProtect;
  logic [1:0] faultCode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  bridge_supervisor #(.DEAD_TICKS(DEAD), .WAIT_CYCLES(WAITC), .SYNC_STAGES(2)) i_bridge_supervisor (
    .clk(clk), .rstN(rstN), .standbyIn(standbyIn), .logicSupplyOk(logicSupplyOk),
    .motorSupplyOk(motorSupplyOk), .overTemp(overTemp), .tempRecovered(tempRecovered),
    .overCurrentRaw(overCurrentRaw), .oscTick(oscTick), .outEnable(outEnable),
    .pumpRun(pumpRun), .pumpReady(pumpReady), .faultCode(faultCode),
    .thermalProtect(thermalProtect)
  );

  // Behavioural reference: bit order {oc, trec, ot, motor, logic, stby}
  logic [5:0] mIn, mA, mB;
  bit mPrev, mOc, mTh;
  int mCnt, mWait;

  function automatic bit mRun();
    return mB[0] && mB[1] && mB[2] && !mTh && !mOc;
  endfunction
  function automatic int mCode();
    if (!(mB[1] && mB[2])) return 1;
    if (mTh) return 2;
    if (mOc) return 3;
    return 0;
  endfunction

  assign mIn = {overCurrentRaw, tempRecovered, overTemp, motorSupplyOk, logicSupplyOk, standbyIn};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mA = '0; mB = '0; mPrev = 0; mOc = 0; mTh = 0; mCnt = 0; mWait = 0;
    end else begin
      bit rise, trip, run;
      int nCnt;
      rise = mB[0] && !mPrev;
      trip = mB[5] && oscTick && (mCnt == DEAD - 1);
      run  = mRun();
      if (!mB[5] || rise) nCnt = 0;
      else if (oscTick)   nCnt = (mCnt == DEAD - 1) ? 0 : mCnt + 1;
      else                nCnt = mCnt;
      if (rise) mOc = 0; else if (trip) mOc = 1;
      if (mB[3]) mTh = 1; else if (rise && mB[4]) mTh = 0;
      if (!run) mWait = 0; else if (mWait < WAITC) mWait++;
      mCnt = nCnt; mPrev = mB[0]; mB = mA; mA = mIn;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) if (!done) begin
    check("R2 pumpRun model", pumpRun, mRun());
    check("R8 pumpReady model", pumpReady, mWait == WAITC);
    check("R8 outEnable model", outEnable, mRun() && mWait == WAITC);
    check("R9 faultCode model", faultCode, mCode());
    check("R6 thermalProtect model", thermalProtect, mTh);
  end

  // Oscillator tick source
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      oscTick = (n % TICK_GAP == 0);
      n++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggleStandby();
    standbyIn = 0; step(6);
    standbyIn = 1; step(6);
  endtask

  task automatic finish();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    step(3);
    // reset state: supplies not yet synchronised -> code 1 (R1)
    check("R1 reset faultCode", faultCode, 1);
    check("R2 reset outEnable", outEnable, 0);
    rstN = 1;
    step(5);
    check("R2 standby low pumpRun", pumpRun, 0);
    check("R9 standby low no fault", faultCode, 0);

    standbyIn = 1;
    step(40);
    check("R8 running outEnable", outEnable, 1);

    // short overcurrent pulse, under dead time (R4)
    overCurrentRaw = 1; step(10); overCurrentRaw = 0; step(4);
    overCurrentRaw = 1; step(10); overCurrentRaw = 0; step(6);
    check("R4 short pulses no trip", faultCode, 0);
    check("R4 short pulses outEnable", outEnable, 1);

    // sustained overcurrent (R3)
    overCurrentRaw = 1; step(30);
    check("R3 trip faultCode", faultCode, 3);
    check("R3 trip outEnable", outEnable, 0);
    overCurrentRaw = 0; step(15);
    check("R5 latched after flag clears", faultCode, 3);
    standbyIn = 0; step(6);
    check("R5 latched while standby low", faultCode, 3);
    standbyIn = 1; step(4);
    check("R5 released by standby rise", faultCode, 0);
    check("R8 wait restarted", outEnable, 0);
    step(20);
    check("R8 drive after wait", outEnable, 1);

    // thermal with no recovery (R6, R7)
    overTemp = 1; step(5); overTemp = 0; step(3);
    check("R6 thermalProtect", thermalProtect, 1);
    check("R6 thermal code", faultCode, 2);
    toggleStandby();
    check("R7 no release without recovery", thermalProtect, 1);
    tempRecovered = 1; step(3);
    toggleStandby();
    check("R7 release with recovery", thermalProtect, 0);
    tempRecovered = 0;

    // stacked faults: priority (R9)
    overTemp = 1; overCurrentRaw = 1; step(30);
    overTemp = 0; overCurrentRaw = 0; logicSupplyOk = 0; step(5);
    check("R9 supply highest", faultCode, 1);
    logicSupplyOk = 1; step(5);
    check("R9 thermal over overcurrent", faultCode, 2);
    tempRecovered = 1; step(3);
    toggleStandby();
    check("R9 all cleared", faultCode, 0);
    tempRecovered = 0;
    step(20);
    check("R8 drive after clear", outEnable, 1);

    // supply dip not latched (R1)
    motorSupplyOk = 0; step(5);
    check("R1 dip pumpRun", pumpRun, 0);
    motorSupplyOk = 1; step(4);
    check("R1 recovered pumpRun", pumpRun, 1);
    check("R1 wait recounted", outEnable, 0);
    step(20);
    check("R1 drive resumes", outEnable, 1);

    // synchroniser latency (R10)
    standbyIn = 0; step(1);
    check("R10 one edge no change", pumpRun, 1);
    step(1);
    check("R10 second edge stops pump", pumpRun, 0);
    step(5);

    finish();
  end
endmodule